// File: doc/BRIEF.md
# SPI-Fed I2S Stereo Serializer

This block accepts 16-bit stereo sample frames from an upstream producer over a simple SPI slave port and plays them to an external DAC as a three-wire I2S stream: a bit clock, a serial data line and a word-select (left/right) clock. The word-select clock is made by dividing the system clock. With a system clock near 24.5 MHz, a half-frame of 256 system clocks gives a frame rate of about 48 kHz. Each channel word is shifted out MSB first. Serial data and word-select changes are locked to falling bit-clock edges, so every word starts at a fixed point in the frame.

Each rising edge of the word-select clock is also reported to the producer as a one-cycle request. The producer then has one frame period to push the next four bytes. Reception and playback are decoupled by a shadow register pair, which holds only one frame ahead of the serializer, so the added latency is small and fixed. When a frame is still incomplete at the handover point, the last samples are played again and a sticky underrun indication is raised.

Top module: `i2s_spi_feeder`

## Requirements
- R1: `dac_lrck` is low for 256 system clocks and then high for 256, repeating without gaps. After reset is released, the first rising edge of `dac_lrck` appears on the output 257 clock edges later.
- R2: `dac_bclk` has a period of 16 system clocks. It is low for the first 8 clocks of each bit slot and high for the last 8, giving 16 slots per half-frame.
- R3: `dac_sd` and `dac_lrck` change only at the same clock edge where `dac_bclk` falls.
- R4: The left word is carried while `dac_lrck` is low and the right word while it is high. The MSB sits in the second slot of its half, and the LSB sits in the first slot of the following half.
- R5: SPI bits are taken on rising `spi_sclk` while `spi_cs_n` is low, MSB first. While `spi_cs_n` is high, any partially received byte is dropped. The bytes of a frame arrive in this order: left high byte, left low byte, right high byte, right low byte.
- R6: `frame_req` is a one-cycle pulse that is high in exactly the cycle where `dac_lrck` goes high.
- R7: A frame completed before a `frame_req` pulse is taken over at that pulse. It is played in the next frame, starting when `dac_lrck` next falls.
- R8: Bytes that arrive after the fourth byte, and before the next `frame_req`, have no effect on the played samples.
- R9: If fewer than four bytes have arrived by a `frame_req` pulse, the previously played samples are repeated and `underrun` goes high. `underrun` stays high until reset.
- R10: `underrun` stays low until at least one complete frame has been received since reset.
- R11: Reset drives every output low and restarts the frame timing. Samples played after reset are zero until a frame is received.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the producer |
| spi_mosi | input | 1 | SPI data from the producer |
| spi_cs_n | input | 1 | SPI chip select, active low |
| dac_bclk | output | 1 | I2S bit clock |
| dac_sd | output | 1 | I2S serial data |
| dac_lrck | output | 1 | I2S word-select clock (low = left) |
| frame_req | output | 1 | One-cycle pulse asking for the next frame |
| underrun | output | 1 | Sticky flag: a frame was missing at handover |

## Verification
The bench decodes the serial stream the way a DAC would, sampling on rising bit-clock edges, and compares every frame with words it derives arithmetically. The words it sends are walking single bits, which expose bit order and off-by-one slot errors; byte-swapped mixed patterns, which expose swapped bytes or channels; and all-ones against all-zeros, which exposes the one-slot delay at channel borders. Other windows send five bytes, three bytes, or a partial byte aborted by chip select. These tell ignored extra data apart from repeated samples, and show that a dropped partial byte does not corrupt the next frame. A second reset followed by silent frames separates an absent producer at startup from a real underrun.

// File: rtl/i2sf_pkg.sv
package i2sf_pkg;
  localparam int unsigned BYTE_W = 8;

  // channel carried in a half-frame, equal to the word-select level
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } chan_e;
endpackage

// File: rtl/i2sf_timebase.sv
module i2sf_timebase #(
  parameter int unsigned HALF     = 256,
  parameter int unsigned BIT_CLKS = 16,
  parameter int unsigned CW       = 9
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt,
  output logic          rise_evt,
  output logic          load_evt
);
  localparam logic [CW-1:0] LAST = CW'(2 * HALF - 1);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  // start of the right half: handover point and producer request
  assign rise_evt = (cnt == CW'(HALF));
  // last cycle of the first left slot: play registers may be reloaded
  assign load_evt = (cnt == CW'(BIT_CLKS - 1));

  assert_period_R1: assert property (@(posedge clk) disable iff (rst)
    $past(cnt) == LAST |-> cnt == '0);
endmodule

// File: rtl/i2sf_spi_rx.sv
module i2sf_spi_rx
  import i2sf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  spi_sclk,
  input  logic                  spi_mosi,
  input  logic                  spi_cs_n,
  input  logic                  frame_clear,
  output logic [SAMPLE_W-1:0]   rx_left,
  output logic [SAMPLE_W-1:0]   rx_right,
  output logic                  rx_full
);
  localparam int unsigned FW   = 2 * SAMPLE_W;
  localparam int unsigned BPF  = FW / BYTE_W;
  localparam int unsigned BCW  = $clog2(BPF + 1);
  localparam int unsigned BITW = $clog2(BYTE_W);
  localparam int unsigned SYNC = 2;

  logic [SYNC-1:0] sclk_sy, mosi_sy, csn_sy;
  logic            sclk_d;
  logic [BITW-1:0] bit_cnt;
  logic [BYTE_W-1:0] byte_sh;
  logic            byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic [BCW-1:0]  byte_cnt;
  logic [FW-1:0]   frame_sr;

  // two-stage synchronizers on all SPI inputs, equal delay on each
  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sy <= '0;
      mosi_sy <= '0;
      csn_sy  <= '1;
      sclk_d  <= 1'b0;
    end else begin
      sclk_sy <= {sclk_sy[SYNC-2:0], spi_sclk};
      mosi_sy <= {mosi_sy[SYNC-2:0], spi_mosi};
      csn_sy  <= {csn_sy[SYNC-2:0], spi_cs_n};
      sclk_d  <= sclk_sy[SYNC-1];
    end
  end

  logic sclk_rise;
  assign sclk_rise = sclk_sy[SYNC-1] & ~sclk_d & ~csn_sy[SYNC-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt   <= '0;
      byte_sh   <= '0;
      byte_done <= 1'b0;
      byte_val  <= '0;
    end else begin
      byte_done <= 1'b0;
      if (csn_sy[SYNC-1]) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        byte_sh <= {byte_sh[BYTE_W-2:0], mosi_sy[SYNC-1]};
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BITW'(BYTE_W - 1)) begin
          byte_done <= 1'b1;
          byte_val  <= {byte_sh[BYTE_W-2:0], mosi_sy[SYNC-1]};
        end
      end
    end
  end

  // frame assembly: first byte ends up in the top byte of frame_sr
  always_ff @(posedge clk) begin
    if (rst) begin
      byte_cnt <= '0;
      frame_sr <= '0;
    end else if (frame_clear) begin
      byte_cnt <= byte_done ? BCW'(1) : '0;
      if (byte_done) frame_sr <= {frame_sr[FW-BYTE_W-1:0], byte_val};
    end else if (byte_done && byte_cnt != BCW'(BPF)) begin
      byte_cnt <= byte_cnt + 1'b1;
      frame_sr <= {frame_sr[FW-BYTE_W-1:0], byte_val};
    end
  end

  assign rx_left  = frame_sr[FW-1:SAMPLE_W];
  assign rx_right = frame_sr[SAMPLE_W-1:0];
  assign rx_full  = (byte_cnt == BCW'(BPF));

  assert_count_cap_R8: assert property (@(posedge clk) disable iff (rst)
    byte_cnt <= BCW'(BPF));
  assert_extra_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !frame_clear) |=> $stable(frame_sr));
endmodule

// File: rtl/i2sf_serializer.sv
module i2sf_serializer
  import i2sf_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned BIT_CLKS = 16,
  parameter int unsigned CW       = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CW-1:0]       cnt,
  input  logic                load_evt,
  input  logic [SAMPLE_W-1:0] next_left,
  input  logic [SAMPLE_W-1:0] next_right,
  output logic                bclk_o,
  output logic                sd_o,
  output logic                lrck_o
);
  localparam int unsigned SLW  = $clog2(SAMPLE_W);
  localparam int unsigned SUBW = $clog2(BIT_CLKS);

  logic [SAMPLE_W-1:0] play_l, play_r;
  chan_e               half;
  logic [SLW-1:0]      slot;
  logic [SUBW-1:0]     sub;
  logic [SLW-1:0]      idx;
  logic                sd_next;

  assign half = chan_e'(cnt[CW-1]);
  assign slot = cnt[CW-2 -: SLW];
  assign sub  = cnt[SUBW-1:0];
  // slot s (1..W-1) carries bit W-s; modulo 2^SLW that is simply -s
  assign idx  = '0 - slot;

  always_comb begin
    if (slot == '0) sd_next = (half == CH_RIGHT) ? play_l[0] : play_r[0];
    else if (half == CH_RIGHT) sd_next = play_r[idx];
    else sd_next = play_l[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      play_l <= '0;
      play_r <= '0;
      bclk_o <= 1'b0;
      sd_o   <= 1'b0;
      lrck_o <= 1'b0;
    end else begin
      if (load_evt) begin
        play_l <= next_left;
        play_r <= next_right;
      end
      bclk_o <= sub[SUBW-1];
      sd_o   <= sd_next;
      lrck_o <= cnt[CW-1];
    end
  end

  assert_sd_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_o) |-> $fell(bclk_o));
  assert_lrck_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(lrck_o) |-> $fell(bclk_o));
endmodule

// File: rtl/i2s_spi_feeder.sv
module i2s_spi_feeder #(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned BIT_CLKS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic spi_sclk,
  input  logic spi_mosi,
  input  logic spi_cs_n,
  output logic dac_bclk,
  output logic dac_sd,
  output logic dac_lrck,
  output logic frame_req,
  output logic underrun
);
  localparam int unsigned HALF = SAMPLE_W * BIT_CLKS;
  localparam int unsigned CW   = $clog2(2 * HALF);

  logic [CW-1:0]       cnt;
  logic                rise_evt, load_evt;
  logic [SAMPLE_W-1:0] rx_left, rx_right;
  logic                rx_full;
  logic [SAMPLE_W-1:0] shadow_l, shadow_r;
  logic                armed;

  i2sf_timebase #(.HALF(HALF), .BIT_CLKS(BIT_CLKS), .CW(CW)) u_tb (
    .clk(clk), .rst(rst), .cnt(cnt), .rise_evt(rise_evt), .load_evt(load_evt)
  );

  i2sf_spi_rx #(.SAMPLE_W(SAMPLE_W)) u_rx (
    .clk(clk), .rst(rst),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
    .frame_clear(rise_evt),
    .rx_left(rx_left), .rx_right(rx_right), .rx_full(rx_full)
  );

  // handover at the word-select rising edge
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_l  <= '0;
      shadow_r  <= '0;
      armed     <= 1'b0;
      underrun  <= 1'b0;
      frame_req <= 1'b0;
    end else begin
      frame_req <= rise_evt;
      if (rise_evt) begin
        if (rx_full) begin
          shadow_l <= rx_left;
          shadow_r <= rx_right;
          armed    <= 1'b1;
        end else if (armed) begin
          underrun <= 1'b1;
        end
      end
    end
  end

  i2sf_serializer #(.SAMPLE_W(SAMPLE_W), .BIT_CLKS(BIT_CLKS), .CW(CW)) u_ser (
    .clk(clk), .rst(rst), .cnt(cnt), .load_evt(load_evt),
    .next_left(shadow_l), .next_right(shadow_r),
    .bclk_o(dac_bclk), .sd_o(dac_sd), .lrck_o(dac_lrck)
  );

  assert_req_with_rise_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(dac_lrck) |-> frame_req);
  assert_req_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    frame_req |=> !frame_req);
  assert_underrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    $past(underrun) |-> underrun);
  assert_underrun_at_req_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> frame_req);
  assert_no_early_underrun_R10: assert property (@(posedge clk) disable iff (rst)
    !armed |-> !underrun);
endmodule

// File: tb/i2s_spi_feeder_test.sv
module i2s_spi_feeder_test;
  localparam int CLK_PERIOD = 10;
  localparam int NW         = 20;
  localparam int HALF       = 256;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic bclk, sd, lrck, freq, und;

  int checks = 0, failures = 0;
  int n = 0;
  bit quiet = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_spi_feeder uut (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(csn),
    .dac_bclk(bclk), .dac_sd(sd), .dac_lrck(lrck), .frame_req(freq), .underrun(und)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at t=%0t", req, act, expv, $time);
    end
  endtask

  function automatic logic [31:0] win_word(int w);
    logic [15:0] l, r;
    if (w == 2) begin l = 16'hFFFF; r = 16'h0000; end
    else if (w % 2 == 1) begin l = 16'h8000 >> (w % 16); r = 16'h0001 << (w % 16); end
    else begin
      l = 16'hA5C3 ^ 16'(w * 16'h1111);
      r = {l[7:0], l[15:8]} ^ 16'h3C3C;
    end
    return {l, r};
  endfunction

  function automatic int win_bytes(int w);
    if (quiet || w >= NW) return 0;
    if (w == 3) return 5;   // one extra byte, R8
    if (w == 4) return 3;   // short frame, R9
    return 4;
  endfunction

  always @(posedge clk) begin
    if (rst) n <= 0;
    else n <= n + 1;
  end

  // model and checker, sampled at falling edges
  logic [31:0] expf [0:63];
  logic [31:0] shadow_m, sr;
  bit armed_m, und_m, prev_bclk, prev_sd;
  int rises, slots, frames_done;

  always @(negedge clk) begin
    int c, k;
    if (rst) begin
      shadow_m = '0; armed_m = 0; und_m = 0; rises = 0; slots = 0; sr = '0;
      for (int i = 0; i < 64; i++) expf[i] = '0;
      prev_bclk = 0; prev_sd = 0;
    end else begin
      if (n == 0) begin
        chk({bclk, sd, lrck, freq, und} == 5'b0, "R11 reset outputs", {bclk, sd, lrck, freq, und}, 0);
      end else begin
        c = (n - 1) % (2 * HALF);
        chk(lrck == (c >= HALF), "R1 lrck", lrck, c >= HALF);
        chk(bclk == ((c % 16) >= 8), "R2 bclk", bclk, (c % 16) >= 8);
        chk(freq == (c == HALF), "R6 frame_req", freq, c == HALF);
      end
      if (sd != prev_sd)
        chk(prev_bclk && !bclk, "R3 sd change off bclk fall", bclk, 0);
      if (freq) begin
        if (win_bytes(rises) >= 4) begin shadow_m = win_word(rises); armed_m = 1; end
        else if (armed_m) und_m = 1;
        if (rises + 1 < 64) expf[rises + 1] = shadow_m;
        rises++;
      end
      chk(und == und_m, "R9/R10 underrun", und, und_m);
      if (!prev_bclk && bclk) begin
        sr = {sr[30:0], sd};
        slots++;
        if (slots >= 33 && (slots - 1) % 32 == 0) begin
          k = (slots - 33) / 32;
          if (k < 64) begin
            chk(sr == expf[k], "R4/R5/R7/R8 frame words", sr, expf[k]);
            frames_done++;
          end
        end
      end
      prev_bclk = bclk; prev_sd = sd;
    end
  end

  task automatic spi_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      repeat (2) @(negedge clk);
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic send_window(input int w);
    logic [31:0] wd;
    int nb;
    wd = win_word(w);
    nb = win_bytes(w);
    if (w == 6) begin
      // aborted partial byte; cs_n high must discard it (R5)
      csn = 1'b0; @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        mosi = 1'b1; repeat (2) @(negedge clk);
        sclk = 1'b1; repeat (2) @(negedge clk);
        sclk = 1'b0;
      end
      csn = 1'b1; repeat (4) @(negedge clk);
    end
    if (nb == 0) return;
    csn = 1'b0; @(negedge clk);
    for (int j = 0; j < nb; j++) spi_byte((j < 4) ? wd[31 - 8*j -: 8] : 8'h5A);
    repeat (2) @(negedge clk);
    csn = 1'b1;
  endtask

  task automatic wait_req();
    while (!freq) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    frames_done = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int w = 0; w < NW; w++) begin
      send_window(w);
      wait_req();
    end
    wait_req();
    wait_req();
    chk(frames_done >= NW + 1, "R7 frames decoded", frames_done, NW + 1);
    chk(und == 1'b1, "R9 underrun sticky", und, 1);
    // phase 2: fresh reset, producer silent
    quiet = 1'b1;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk({bclk, sd, lrck, freq, und} == 5'b0, "R11 outputs after reset", {bclk, sd, lrck, freq, und}, 0);
    for (int i = 0; i < 3; i++) wait_req();
    chk(und == 1'b0, "R10 silent startup no underrun", und, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule